// File: doc/BRIEF.md
# Nested Priority Event Controller

This block decides which of sixteen event levels a processor core should service next. Each level has a request line. A rising demand on a line is captured in a latch register. A mask register decides which latched levels may be serviced. A pending register records every level that the core has accepted and not yet returned from, so it also records how deeply events are nested. Level 0 has the highest priority and level 15 the lowest. The levels are assigned as follows:

- 0: emulation
- 1: reset
- 2: non-maskable interrupt
- 3: exception
- 4: reserved
- 5: hardware error
- 6: core timer
- 7 to 15: general-purpose levels fed by a system-level aggregator

The controller presents one winning level number together with a valid flag. The core accepts the presented event with a one-cycle strobe and signals the end of its handler with a return strobe. A global enable flag gates only the general-purpose levels, and it leaves the mask register untouched. Software reaches the three registers through a small register port. Access to the mask and pending registers requires a supervisor-mode qualifier.

Top module: `cec_core_evt_ctrl`

## Requirements
- R1: After reset the latch and pending registers are 0, the mask register reads 0x002F, the global enable is off, and `evt_valid_o` is low.
- R2: A high level on `evt_req_i[n]` at a clock edge sets latch bit n. The bit stays set until that level is accepted or software clears it.
- R3: Among levels that are latched, unmasked and not gated, the lowest-numbered one is presented on `evt_num_o`.
- R4: A latched level whose mask bit is 0 is held and never presented. Mask bits 0 to 3 and 5 always read 1. Bit 4 is always 0 in the latch, mask and pending registers.
- R5: A level is presented only if its number is strictly less than the lowest-numbered set pending bit. A level equal to or greater than that bit waits.
- R6: When `accept_i` is high while `evt_valid_o` is high, the presented level's latch bit clears and its pending bit sets at the same clock edge. When `accept_i` is high with `evt_valid_o` low, nothing changes.
- R7: `rtn_i` clears only the lowest-numbered set pending bit.
- R8: A latch write updates only the bits whose mask bit is 0. Bits whose mask bit is 1 keep their value. Latch writes need no supervisor qualifier.
- R9: Without `super_i`, reads of the mask or pending register return 0 and writes to the mask register are ignored.
- R10: Writes to the pending register never change it.
- R11: Levels 7 to 15 can be presented only while the global enable is on. `gie_set_i` turns it on, `gie_clr_i` turns it off, and the clear wins when both are high. Neither strobe changes the mask register, and levels 5 and 6 are not gated.
- R12: `reg_sel_i` selects the register: 0 is the latch, 1 is the mask, 2 is pending, and 3 reads as 0 and writes nothing. Reads are combinational, and writes take effect at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_req_i | input | 16 | Event request lines, bit n is level n |
| accept_i | input | 1 | Core accepts the presented event |
| rtn_i | input | 1 | Return from the innermost active event |
| gie_set_i | input | 1 | Turn the general-purpose global enable on |
| gie_clr_i | input | 1 | Turn the general-purpose global enable off |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select (0 latch, 1 mask, 2 pending) |
| reg_wdata_i | input | 16 | Register write data |
| super_i | input | 1 | Supervisor-mode qualifier for the access |
| reg_rdata_o | output | 16 | Read data of the selected register |
| evt_valid_o | output | 1 | A level is being presented |
| evt_num_o | output | 4 | Number of the presented level |

## Verification
The arbitration is driven with several kinds of input:

- A single masked request shows that masking holds an event latched but unserviced.
- Requests that arrive while a lower-priority event is pending show that the nesting gate lets a higher-priority level through.
- A second arrival of lower priority shows that the same gate holds an equal or lower-priority level back.
- Toggling the global enable, including both strobes in the same cycle, separates the general-purpose levels from levels 5 and 6.

Register-port patterns cover three things:

- Latch writes under mixed masks.
- Mask writes with and without the supervisor qualifier.
- Pending writes, which must have no effect.

Their effects are observed through read-back and the presented level.

// File: rtl/cec_pkg.sv
package cec_pkg;
  typedef enum logic [1:0] {
    SEL_LATCH = 2'd0,
    SEL_MASK  = 2'd1,
    SEL_PEND  = 2'd2,
    SEL_NONE  = 2'd3
  } cec_sel_e;
endpackage

// File: rtl/cec_prio_enc.sv
module cec_prio_enc #(
  parameter int N = 16,
  parameter int W = $clog2(N)
) (
  input  logic [N-1:0] vec_i,
  output logic         found_o,
  output logic [W-1:0] idx_o
);
  function automatic logic [W-1:0] low_idx(input logic [N-1:0] v);
    logic [W-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (v[i]) r = W'(i);
    end
    return r;
  endfunction

  assign found_o = |vec_i;
  assign idx_o   = low_idx(vec_i);
endmodule

// File: rtl/cec_latch_reg.sv
module cec_latch_reg #(
  parameter int           N    = 16,
  parameter int           W    = $clog2(N),
  parameter logic [N-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  input  logic         wr_en_i,
  input  logic [N-1:0] wdata_i,
  input  logic [N-1:0] mask_i,
  input  logic         clr_en_i,
  input  logic [W-1:0] clr_idx_i,
  output logic [N-1:0] latch_o
);
  logic [N-1:0] latch_q, latch_d, clr_vec;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      clr_vec[i] = clr_en_i && (W'(i) == clr_idx_i);
    end
  end

  always_comb begin
    latch_d = latch_q;
    if (wr_en_i) latch_d = (latch_q & mask_i) | (wdata_i & ~mask_i);
    latch_d = (latch_d & ~clr_vec) | req_i;
    latch_d = latch_d & IMPL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_q <= '0;
    else        latch_q <= latch_d;
  end

  assign latch_o = latch_q;
endmodule

// File: rtl/cec_mask_reg.sv
module cec_mask_reg #(
  parameter int           N     = 16,
  parameter logic [N-1:0] FIXED = '0,
  parameter logic [N-1:0] IMPL  = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] mask_o
);
  localparam logic [N-1:0] RST_VAL = FIXED & IMPL;
  logic [N-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= RST_VAL;
    else if (wr_en_i) mask_q <= (wdata_i | FIXED) & IMPL;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/cec_nest_track.sv
module cec_nest_track #(
  parameter int           N    = 16,
  parameter int           W    = $clog2(N),
  parameter logic [N-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en_i,
  input  logic [W-1:0] set_idx_i,
  input  logic         ret_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_q, pend_d, set_vec, ret_vec;

  function automatic logic [N-1:0] isolate_low(input logic [N-1:0] v);
    return v & (~v + N'(1));
  endfunction

  always_comb begin
    for (int i = 0; i < N; i++) begin
      set_vec[i] = set_en_i && (W'(i) == set_idx_i);
    end
    ret_vec = ret_i ? isolate_low(pend_q) : '0;
    pend_d  = ((pend_q & ~ret_vec) | set_vec) & IMPL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/cec_core_evt_ctrl.sv
module cec_core_evt_ctrl #(
  parameter int                    NUM_LVL   = 16,
  parameter int                    GP_FIRST  = 7,
  parameter logic [NUM_LVL-1:0]    RSVD_MAP  = 16'h0010,
  parameter logic [NUM_LVL-1:0]    FIXED_MAP = 16'h002F
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_LVL-1:0]         evt_req_i,
  input  logic                       accept_i,
  input  logic                       rtn_i,
  input  logic                       gie_set_i,
  input  logic                       gie_clr_i,
  input  logic                       reg_wr_i,
  input  logic [1:0]                 reg_sel_i,
  input  logic [NUM_LVL-1:0]         reg_wdata_i,
  input  logic                       super_i,
  output logic [NUM_LVL-1:0]         reg_rdata_o,
  output logic                       evt_valid_o,
  output logic [$clog2(NUM_LVL)-1:0] evt_num_o
);
  import cec_pkg::*;

  localparam int               LVL_W = $clog2(NUM_LVL);
  localparam logic [NUM_LVL-1:0] IMPL = ~RSVD_MAP;

  cec_sel_e             sel;
  logic [NUM_LVL-1:0]   latch_q, mask_q, pend_q, gp_map, gate_map, eligible;
  logic                 gie_q;
  logic                 latch_wr, mask_wr, accept_fire;
  logic                 win_found, top_found, win_ok;
  logic [LVL_W-1:0]     win_idx, top_idx;

  assign sel = cec_sel_e'(reg_sel_i);

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_gp
    assign gp_map[g] = (g >= GP_FIRST);
  end

  assign latch_wr    = reg_wr_i && (sel == SEL_LATCH);
  assign mask_wr     = reg_wr_i && (sel == SEL_MASK) && super_i;
  assign accept_fire = accept_i && evt_valid_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         gie_q <= 1'b0;
    else if (gie_clr_i) gie_q <= 1'b0;
    else if (gie_set_i) gie_q <= 1'b1;
  end

  cec_latch_reg #(.N(NUM_LVL), .W(LVL_W), .IMPL(IMPL)) u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (evt_req_i),
    .wr_en_i   (latch_wr),
    .wdata_i   (reg_wdata_i),
    .mask_i    (mask_q),
    .clr_en_i  (accept_fire),
    .clr_idx_i (win_idx),
    .latch_o   (latch_q)
  );

  cec_mask_reg #(.N(NUM_LVL), .FIXED(FIXED_MAP), .IMPL(IMPL)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en_i (mask_wr),
    .wdata_i (reg_wdata_i),
    .mask_o  (mask_q)
  );

  cec_nest_track #(.N(NUM_LVL), .W(LVL_W), .IMPL(IMPL)) u_nest (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_en_i  (accept_fire),
    .set_idx_i (win_idx),
    .ret_i     (rtn_i),
    .pend_o    (pend_q)
  );

  assign gate_map = gie_q ? '1 : ~gp_map;
  assign eligible = latch_q & mask_q & gate_map;

  cec_prio_enc #(.N(NUM_LVL), .W(LVL_W)) u_win_enc (
    .vec_i   (eligible),
    .found_o (win_found),
    .idx_o   (win_idx)
  );

  cec_prio_enc #(.N(NUM_LVL), .W(LVL_W)) u_top_enc (
    .vec_i   (pend_q),
    .found_o (top_found),
    .idx_o   (top_idx)
  );

  assign win_ok      = !top_found || (win_idx < top_idx);
  assign evt_valid_o = win_found && win_ok;
  assign evt_num_o   = win_idx;

  always_comb begin
    unique case (sel)
      SEL_LATCH: reg_rdata_o = latch_q;
      SEL_MASK:  reg_rdata_o = super_i ? mask_q : '0;
      SEL_PEND:  reg_rdata_o = super_i ? pend_q : '0;
      default:   reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/cec_core_evt_ctrl_chk.sv
module cec_core_evt_ctrl_chk #(
  parameter int                 N         = 16,
  parameter int                 W         = $clog2(N),
  parameter int                 GP_FIRST  = 7,
  parameter logic [N-1:0]       RSVD_MAP  = 16'h0010,
  parameter logic [N-1:0]       FIXED_MAP = 16'h002F
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] evt_req_i,
  input logic         accept_i,
  input logic         rtn_i,
  input logic         reg_wr_i,
  input logic [1:0]   reg_sel_i,
  input logic         super_i,
  input logic         evt_valid_o,
  input logic [W-1:0] evt_num_o,
  input logic [N-1:0] latch_q,
  input logic [N-1:0] mask_q,
  input logic [N-1:0] pend_q,
  input logic         gie_q,
  input logic         accept_fire
);
  logic [N-1:0] at_or_above;
  always_comb begin
    for (int i = 0; i < N; i++) at_or_above[i] = (W'(i) <= evt_num_o);
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((latch_q | mask_q | pend_q) & RSVD_MAP) == '0);  // R4
  AST_FIXED_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q & FIXED_MAP) == FIXED_MAP);  // R4
  AST_VALID_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid_o |-> (latch_q[evt_num_o] && mask_q[evt_num_o]));  // R4
  AST_NEST_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid_o |-> ((pend_q & at_or_above) == '0));  // R5
  AST_ACCEPT_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_i && evt_valid_o) |=> pend_q[$past(evt_num_o)]);  // R6
  AST_ACCEPT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_i && evt_valid_o && !evt_req_i[evt_num_o]) |=> !latch_q[$past(evt_num_o)]);  // R6
  AST_PEND_ONLY_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept_fire && !rtn_i) |=> $stable(pend_q));  // R10
  AST_MASK_USER_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_sel_i == 2'd1 && !super_i) |=> $stable(mask_q));  // R9
  AST_RTN_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (rtn_i && !accept_fire && pend_q != '0) |=>
      ($countones(pend_q) + 1 == $past($countones(pend_q))));  // R7
  AST_GP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid_o && !gie_q) |-> (int'(evt_num_o) < GP_FIRST));  // R11
endmodule

bind cec_core_evt_ctrl cec_core_evt_ctrl_chk #(
  .N(NUM_LVL), .W($clog2(NUM_LVL)), .GP_FIRST(GP_FIRST),
  .RSVD_MAP(RSVD_MAP), .FIXED_MAP(FIXED_MAP)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .evt_req_i   (evt_req_i),
  .accept_i    (accept_i),
  .rtn_i       (rtn_i),
  .reg_wr_i    (reg_wr_i),
  .reg_sel_i   (reg_sel_i),
  .super_i     (super_i),
  .evt_valid_o (evt_valid_o),
  .evt_num_o   (evt_num_o),
  .latch_q     (latch_q),
  .mask_q      (mask_q),
  .pend_q      (pend_q),
  .gie_q       (gie_q),
  .accept_fire (accept_fire)
);

// File: tb/cec_core_evt_ctrl_tb.sv
module cec_core_evt_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] evt_req = '0;
  logic        accept = 1'b0, rtn = 1'b0, gset = 1'b0, gclr = 1'b0;
  logic        reg_wr = 1'b0, sup = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        evt_valid;
  logic [3:0]  evt_num;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cec_core_evt_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .evt_req_i(evt_req), .accept_i(accept),
    .rtn_i(rtn), .gie_set_i(gset), .gie_clr_i(gclr), .reg_wr_i(reg_wr),
    .reg_sel_i(reg_sel), .reg_wdata_i(wdata), .super_i(sup),
    .reg_rdata_o(rdata), .evt_valid_o(evt_valid), .evt_num_o(evt_num)
  );

  typedef struct packed {
    logic [15:0] req;
    logic        acc;
    logic        ret;
    logic        gs;
    logic        gc;
    logic        wr;
    logic [1:0]  sel;
    logic [15:0] wd;
    logic        sp;
    logic        ev;
    logic [3:0]  en;
  } vec_t;

  // Sequence from reset: R2 R3 R4 R5 R6 R7 R11
  localparam vec_t VECS [NV] = '{
    '{16'h0040, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b0, 4'd0},
    '{16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 16'hFFC0, 1'b1, 1'b1, 4'd6},
    '{16'h0200, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b1, 4'd6},
    '{16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b1, 4'd6},
    '{16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b0, 4'd0},
    '{16'h0020, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b1, 4'd5},
    '{16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b0, 4'd0},
    '{16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b0, 4'd0},
    '{16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b1, 4'd9},
    '{16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b0, 4'd0},
    '{16'h0000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b0, 4'd0},
    '{16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b1, 4'd9},
    '{16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b0, 4'd0},
    '{16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b0, 4'd0}
  };

  task automatic check_eq(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", tag, act, exp);
    end
  endtask

  task automatic check_evt(input string tag, input logic ev, input logic [3:0] en);
    checks++;
    if (evt_valid !== ev || (ev && evt_num !== en)) begin
      failures++;
      $display("FAIL %s actual valid=%0b num=%0d expected valid=%0b num=%0d",
               tag, evt_valid, evt_num, ev, en);
    end
  endtask

  // Drive one cycle of inputs at a negedge, return at the following negedge.
  task automatic step(input logic [15:0] rq, input logic ac, input logic rt,
                      input logic gs, input logic gc, input logic wr,
                      input logic [1:0] sl, input logic [15:0] wd, input logic sp);
    evt_req = rq; accept = ac; rtn = rt; gset = gs; gclr = gc;
    reg_wr = wr; reg_sel = sl; wdata = wd; sup = sp;
    @(negedge clk);
    evt_req = '0; accept = 0; rtn = 0; gset = 0; gclr = 0; reg_wr = 0;
  endtask

  task automatic idle();
    step(16'h0, 0, 0, 0, 0, 0, 2'd0, 16'h0, 0);
  endtask

  task automatic wr_reg(input logic [1:0] sl, input logic [15:0] wd, input logic sp);
    step(16'h0, 0, 0, 0, 0, 1, sl, wd, sp);
  endtask

  task automatic rd_reg(input logic [1:0] sl, input logic sp, output logic [15:0] v);
    reg_wr = 0; reg_sel = sl; sup = sp;
    #1;
    v = rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] v;
    do_reset();

    // R1 R12: reset state
    rd_reg(2'd0, 1, v); check_eq("R1 latch after reset", v, 16'h0000);
    rd_reg(2'd1, 1, v); check_eq("R1 mask after reset", v, 16'h002F);
    rd_reg(2'd2, 1, v); check_eq("R1 pend after reset", v, 16'h0000);
    check_evt("R1 no event after reset", 1'b0, 4'd0);

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].req, VECS[i].acc, VECS[i].ret, VECS[i].gs, VECS[i].gc,
           VECS[i].wr, VECS[i].sel, VECS[i].wd, VECS[i].sp);
      check_evt($sformatf("R3/R5/R6/R7/R11 vector %0d", i), VECS[i].ev, VECS[i].en);
    end

    // R4: fixed bits and reserved bit in the mask
    rd_reg(2'd1, 1, v); check_eq("R4 mask fixed/reserved", v, 16'hFFEF);
    wr_reg(2'd1, 16'h0000, 1);
    rd_reg(2'd1, 1, v); check_eq("R4 mask cannot clear fixed", v, 16'h002F);

    // R8: latch write lands only on masked-off bits
    wr_reg(2'd0, 16'hFFFF, 0);
    rd_reg(2'd0, 0, v); check_eq("R8 latch write masked bits", v, 16'hFFC0);
    check_evt("R4 masked latch held", 1'b0, 4'd0);
    wr_reg(2'd1, 16'hFFFF, 1);
    check_evt("R3 lowest of many", 1'b1, 4'd6);
    wr_reg(2'd0, 16'h0000, 0);
    rd_reg(2'd0, 0, v); check_eq("R8 unmasked bits kept", v, 16'hFFC0);
    wr_reg(2'd1, 16'h0000, 1);
    wr_reg(2'd0, 16'h0000, 0);
    rd_reg(2'd0, 0, v); check_eq("R8 latch cleared", v, 16'h0000);

    // R9: supervisor qualifier
    wr_reg(2'd1, 16'hFFFF, 0);
    rd_reg(2'd1, 1, v); check_eq("R9 user mask write ignored", v, 16'h002F);
    rd_reg(2'd1, 0, v); check_eq("R9 user mask read zero", v, 16'h0000);

    // R2 R6: capture, persistence, accept
    step(16'h0008, 0, 0, 0, 0, 0, 2'd0, 16'h0, 0);
    check_evt("R2 captured level 3", 1'b1, 4'd3);
    idle();
    check_evt("R2 latch persists", 1'b1, 4'd3);
    step(16'h0, 1, 0, 0, 0, 0, 2'd0, 16'h0, 0);
    check_evt("R6 accepted no longer presented", 1'b0, 4'd0);
    rd_reg(2'd2, 1, v); check_eq("R6 pend set", v, 16'h0008);
    rd_reg(2'd0, 1, v); check_eq("R6 latch cleared", v, 16'h0000);
    rd_reg(2'd2, 0, v); check_eq("R9 user pend read zero", v, 16'h0000);

    // R10: pending not writable
    wr_reg(2'd2, 16'h0000, 1);
    rd_reg(2'd2, 1, v); check_eq("R10 pend write ignored", v, 16'h0008);

    // R5 R7: nesting
    step(16'h0009, 0, 0, 0, 0, 0, 2'd0, 16'h0, 0);
    check_evt("R5 higher level preempts", 1'b1, 4'd0);
    step(16'h0, 1, 0, 0, 0, 0, 2'd0, 16'h0, 0);
    check_evt("R5 equal level blocked", 1'b0, 4'd0);
    rd_reg(2'd2, 1, v); check_eq("R6 nested pend", v, 16'h0009);
    step(16'h0, 0, 1, 0, 0, 0, 2'd0, 16'h0, 0);
    rd_reg(2'd2, 1, v); check_eq("R7 lowest pend cleared", v, 16'h0008);
    check_evt("R5 level equal to pending waits", 1'b0, 4'd0);
    step(16'h0, 0, 1, 0, 0, 0, 2'd0, 16'h0, 0);
    check_evt("R5 released after return", 1'b1, 4'd3);
    step(16'h0, 1, 0, 0, 0, 0, 2'd0, 16'h0, 0);
    step(16'h0, 0, 1, 0, 0, 0, 2'd0, 16'h0, 0);
    rd_reg(2'd2, 1, v); check_eq("R7 all returned", v, 16'h0000);

    // R6: accept with nothing presented
    step(16'h0, 1, 0, 0, 0, 0, 2'd0, 16'h0, 0);
    rd_reg(2'd2, 1, v); check_eq("R6 stray accept ignored", v, 16'h0000);

    // R12: unused select
    rd_reg(2'd3, 1, v); check_eq("R12 select 3 reads zero", v, 16'h0000);

    // R11: global enable gating, mask unchanged
    wr_reg(2'd1, 16'hFFFF, 1);
    step(16'h0, 0, 0, 0, 1, 0, 2'd0, 16'h0, 0);
    step(16'h0080, 0, 0, 0, 0, 0, 2'd0, 16'h0, 0);
    check_evt("R11 level 7 gated", 1'b0, 4'd0);
    rd_reg(2'd1, 1, v); check_eq("R11 mask unchanged", v, 16'hFFEF);
    step(16'h0, 0, 0, 1, 0, 0, 2'd0, 16'h0, 0);
    check_evt("R11 level 7 after enable", 1'b1, 4'd7);

    // R1: reset mid-run
    do_reset();
    rd_reg(2'd0, 1, v); check_eq("R1 latch after second reset", v, 16'h0000);
    rd_reg(2'd1, 1, v); check_eq("R1 mask after second reset", v, 16'h002F);
    check_evt("R1 no event after second reset", 1'b0, 4'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule